// File: doc/BRIEF.md
# OTP Controller Command Engine

This block is the CPU-facing front end of a one-time-programmable fuse memory. Software talks to it through a small word-addressed register port. It loads a command code, a row address and, for programming, the row data. It then raises a start flag and polls a status word until the command reports completion. Every read or program command moves exactly one row. A row is one 32-bit word in the base build and two 32-bit words in the wide build (`WIDE=1`). The fuse array is a behavioural model: each bit starts at 0 and can only be set to 1.

Programming is locked after reset. To unlock it, software issues four program-enable commands whose write-data words are 0xF, 0x4, 0x8 and 0xD, in that order. Once the fourth one is accepted, the program-OK status flag rises. Until then, program commands finish without touching the array. A program-disable command locks the array again.

A command is launched when the start flag goes from 0 to 1. It stays busy for `BUSY_CYCLES` clock cycles and then reports done. The done flag holds until software writes the start flag back to 0.

Top module: `otp_cmd_engine`

## Requirements
- R1: After reset, every readable register reads 0: mode, command, start, status, address, write data and read data.
- R2: The register offsets are fixed: mode 0x00 (bit 0 enables access), command 0x04, start 0x08 (bit 0), status 0x0C, address 0x28, write word 0x2C, read word 0x10. In the wide build the upper read word is at 0x5C and the upper write word is at 0x64. The command register keeps only bits [5:0] and the address register keeps only bits [15:0]. Upper bits written to either register read back as 0.
- R3: While mode bit 0 is 0, writing 1 to the start flag launches nothing: status busy (bit 0) and done (bit 1) both stay 0.
- R4: A launch happens only when the start flag changes from 0 to 1. Status bit 0 (busy) is 1 from the launch edge until done. Status bit 1 (done) rises exactly `BUSY_CYCLES` clock edges after the start write. Done clears on the edge where 0 is written to the start flag.
- R5: The read command (code 0x00) copies the addressed row into the read data word(s).
- R6: Four program-enable commands (code 0x02), carrying the write words 0xF, 0x4, 0x8 and 0xD in that order, set program-OK (status bit 2) on completion of the fourth.
- R7: A program-enable command whose write word does not match the expected next value returns the unlock tracker to its first step. The rest of a broken sequence then leaves program-OK at 0.
- R8: With program-OK set, the program command (code 0x08) ORs the write data into the addressed row. Bits already at 1 stay 1.
- R9: With program-OK clear, a program command completes (done sets) and leaves the array and program-OK unchanged.
- R10: The program-disable command (code 0x03) clears program-OK and completes with done. Later program commands leave the array unchanged.
- R11: An address at or above `NUM_ROWS` reads back as an all-zero row, and programming it changes no row.
- R12: Any other command code completes with done and changes neither the array, program-OK nor the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at `bus_addr` (combinational) |

## Verification
A wrong unlock step or program-OK flag shows up in status bit 2 at the next poll after the fourth enable command. If the gate fails, the array content changes, and a read command reveals that one busy window later. A miscounted busy counter shifts the edge at which done rises, so cycle-accurate polling catches it in the same command. Array corruption from a stray write or a lost OR merge appears in the read-data words as soon as the affected row is read back.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam logic [7:0] OFS_MODE   = 8'h00;
  localparam logic [7:0] OFS_CMD    = 8'h04;
  localparam logic [7:0] OFS_START  = 8'h08;
  localparam logic [7:0] OFS_STAT   = 8'h0C;
  localparam logic [7:0] OFS_RD_LO  = 8'h10;
  localparam logic [7:0] OFS_ADDR   = 8'h28;
  localparam logic [7:0] OFS_WR_LO  = 8'h2C;
  localparam logic [7:0] OFS_RD_HI  = 8'h5C;
  localparam logic [7:0] OFS_WR_HI  = 8'h64;

  localparam int CMD_W  = 6;
  localparam int ADDR_W = 16;

  localparam logic [CMD_W-1:0] OP_READ    = 6'h00;
  localparam logic [CMD_W-1:0] OP_UNLOCK  = 6'h02;
  localparam logic [CMD_W-1:0] OP_LOCK    = 6'h03;
  localparam logic [CMD_W-1:0] OP_PROGRAM = 6'h08;

  // Expected write word for each step of the unlock sequence
  function automatic logic [31:0] unlock_key(input logic [1:0] step);
    case (step)
      2'd0:    unlock_key = 32'hF;
      2'd1:    unlock_key = 32'h4;
      2'd2:    unlock_key = 32'h8;
      default: unlock_key = 32'hD;
    endcase
  endfunction

  function automatic logic row_valid(input logic [ADDR_W-1:0] a, input int rows);
    row_valid = (32'(a) < rows);
  endfunction

  // Fuses only blow: merged row keeps every set bit
  function automatic logic [63:0] fuse_merge(input logic [63:0] old_v, input logic [63:0] new_v);
    fuse_merge = old_v | new_v;
  endfunction

endpackage

// File: rtl/otp_regbank.sv
module otp_regbank
  import otp_pkg::*;
#(
  parameter bit WIDE  = 1'b0,
  parameter int ROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              prog_ok_i,
  input  logic [ROW_W-1:0]  rrow_i,
  output logic              mode_en_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ROW_W-1:0]  wrow_o,
  output logic              start_set_o,
  output logic              start_clr_o
);

  logic        mode_q;
  logic        start_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0] wlo_q;
  logic [31:0] whi_rd;
  logic [31:0] rhi_rd;

  wire wr_start = bus_we && (bus_addr == OFS_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      start_q <= 1'b0;
      cmd_q   <= '0;
      addr_q  <= '0;
      wlo_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_MODE:  mode_q  <= bus_wdata[0];
        OFS_CMD:   cmd_q   <= bus_wdata[CMD_W-1:0];
        OFS_START: start_q <= bus_wdata[0];
        OFS_ADDR:  addr_q  <= bus_wdata[ADDR_W-1:0];
        OFS_WR_LO: wlo_q   <= bus_wdata;
        default:   ;
      endcase
    end
  end

  generate
    if (WIDE) begin : g_wide
      logic [31:0] whi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              whi_q <= '0;
        else if (bus_we && bus_addr == OFS_WR_HI) whi_q <= bus_wdata;
      end
      assign whi_rd = whi_q;
      assign rhi_rd = rrow_i[ROW_W-1:32];
      assign wrow_o = {whi_q, wlo_q};
    end else begin : g_narrow
      assign whi_rd = '0;
      assign rhi_rd = '0;
      assign wrow_o = wlo_q;
    end
  endgenerate

  assign start_set_o = wr_start && bus_wdata[0] && !start_q;
  assign start_clr_o = wr_start && !bus_wdata[0];
  assign mode_en_o   = mode_q;
  assign cmd_o       = cmd_q;
  assign addr_o      = addr_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_MODE:  bus_rdata = {31'b0, mode_q};
      OFS_CMD:   bus_rdata = {{(32-CMD_W){1'b0}}, cmd_q};
      OFS_START: bus_rdata = {31'b0, start_q};
      OFS_STAT:  bus_rdata = {29'b0, prog_ok_i, done_i, busy_i};
      OFS_ADDR:  bus_rdata = {{(32-ADDR_W){1'b0}}, addr_q};
      OFS_WR_LO: bus_rdata = wlo_q;
      OFS_RD_LO: bus_rdata = rrow_i[31:0];
      OFS_WR_HI: bus_rdata = whi_rd;
      OFS_RD_HI: bus_rdata = rhi_rd;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/otp_sequencer.sv
module otp_sequencer
  import otp_pkg::*;
#(
  parameter int BUSY_CYCLES = 3,
  parameter int ROW_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_set_i,
  input  logic              start_clr_i,
  input  logic              mode_en_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ROW_W-1:0]  wrow_i,
  output logic              launch_o,
  output logic              exec_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CMD_W-1:0]  cmd_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [ROW_W-1:0]  wrow_q_o
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  assign launch_o = start_set_i && mode_en_i && !busy_q;
  assign exec_o   = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      cmd_q_o  <= '0;
      addr_q_o <= '0;
      wrow_q_o <= '0;
    end else begin
      if (launch_o) begin
        cnt_q    <= CNT_LOAD;
        busy_q   <= 1'b1;
        done_q   <= 1'b0;
        cmd_q_o  <= cmd_i;
        addr_q_o <= addr_i;
        wrow_q_o <= wrow_i;
      end else if (exec_o) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        if (busy_q)      cnt_q  <= cnt_q - CNT_W'(1);
        if (start_clr_i) done_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/otp_unlock.sv
module otp_unlock
  import otp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exec_unlock_i,
  input  logic        exec_lock_i,
  input  logic [31:0] key_i,
  output logic        prog_ok_o
);

  logic [1:0] step_q;
  logic       ok_q;
  wire        key_hit = (key_i == unlock_key(step_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      ok_q   <= 1'b0;
    end else if (exec_lock_i) begin
      step_q <= '0;
      ok_q   <= 1'b0;
    end else if (exec_unlock_i) begin
      if (!key_hit) begin
        step_q <= '0;
      end else if (step_q == 2'd3) begin
        step_q <= '0;
        ok_q   <= 1'b1;
      end else begin
        step_q <= step_q + 2'd1;
      end
    end
  end

  assign prog_ok_o = ok_q;

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int ROWS  = 64,
  parameter int ROW_W = 32,
  parameter int IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ROW_W-1:0] wdata_i,
  output logic [ROW_W-1:0] rdata_o
);

  logic [ROW_W-1:0] cell_q [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) cell_q[r] <= '0;
    end else if (we_i) begin
      cell_q[idx_i] <= ROW_W'(otp_pkg::fuse_merge(64'(cell_q[idx_i]), 64'(wdata_i)));
    end
  end

  assign rdata_o = cell_q[idx_i];

endmodule

// File: rtl/otp_cmd_engine.sv
module otp_cmd_engine
  import otp_pkg::*;
#(
  parameter bit WIDE        = 1'b0,
  parameter int NUM_ROWS    = 64,
  parameter int BUSY_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int ROW_W = WIDE ? 64 : 32;
  localparam int IDX_W = $clog2(NUM_ROWS);

  logic              mode_en_w;
  logic [CMD_W-1:0]  cmd_w;
  logic [ADDR_W-1:0] addr_w;
  logic [ROW_W-1:0]  wrow_w;
  logic              start_set_w;
  logic              start_clr_w;
  logic              launch_w;
  logic              exec_w;
  logic              busy_w;
  logic              done_w;
  logic [CMD_W-1:0]  cmd_q_w;
  logic [ADDR_W-1:0] addr_q_w;
  logic [ROW_W-1:0]  wrow_q_w;
  logic              prog_ok_w;
  logic [ROW_W-1:0]  arr_rd_w;
  logic [ROW_W-1:0]  rrow_q;

  // Named internal events for the checker
  wire row_hit_w     = row_valid(addr_q_w, NUM_ROWS);
  wire exec_read_w   = exec_w && (cmd_q_w == OP_READ);
  wire exec_unlock_w = exec_w && (cmd_q_w == OP_UNLOCK);
  wire exec_lock_w   = exec_w && (cmd_q_w == OP_LOCK);
  wire exec_prog_w   = exec_w && (cmd_q_w == OP_PROGRAM);
  wire fuse_we_w     = exec_prog_w && prog_ok_w && row_hit_w;

  otp_regbank #(.WIDE(WIDE), .ROW_W(ROW_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_i(busy_w), .done_i(done_w), .prog_ok_i(prog_ok_w), .rrow_i(rrow_q),
    .mode_en_o(mode_en_w), .cmd_o(cmd_w), .addr_o(addr_w), .wrow_o(wrow_w),
    .start_set_o(start_set_w), .start_clr_o(start_clr_w)
  );

  otp_sequencer #(.BUSY_CYCLES(BUSY_CYCLES), .ROW_W(ROW_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_set_i(start_set_w), .start_clr_i(start_clr_w), .mode_en_i(mode_en_w),
    .cmd_i(cmd_w), .addr_i(addr_w), .wrow_i(wrow_w),
    .launch_o(launch_w), .exec_o(exec_w), .busy_o(busy_w), .done_o(done_w),
    .cmd_q_o(cmd_q_w), .addr_q_o(addr_q_w), .wrow_q_o(wrow_q_w)
  );

  otp_unlock u_unlock (
    .clk(clk), .rst_n(rst_n),
    .exec_unlock_i(exec_unlock_w), .exec_lock_i(exec_lock_w),
    .key_i(wrow_q_w[31:0]), .prog_ok_o(prog_ok_w)
  );

  otp_fuse_array #(.ROWS(NUM_ROWS), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_fuses (
    .clk(clk), .rst_n(rst_n),
    .we_i(fuse_we_w), .idx_i(addr_q_w[IDX_W-1:0]),
    .wdata_i(wrow_q_w), .rdata_o(arr_rd_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rrow_q <= '0;
    else if (exec_read_w) rrow_q <= row_hit_w ? arr_rd_w : '0;
  end

endmodule

// File: rtl/otp_cmd_engine_chk.sv
module otp_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_en,
  input logic start_clr,
  input logic launch,
  input logic busy,
  input logic done,
  input logic prog_ok,
  input logic exec_unlock,
  input logic exec_lock
);

  // R3
  busy_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mode_en));

  // R4
  launch_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R4
  done_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> ($past(start_clr) || $past(launch)));

  // R6
  prog_ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_ok) |-> $past(exec_unlock));

  // R10
  lock_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_lock |=> !prog_ok);

endmodule

bind otp_cmd_engine otp_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en_w), .start_clr(start_clr_w),
  .launch(launch_w), .busy(busy_w), .done(done_w), .prog_ok(prog_ok_w),
  .exec_unlock(exec_unlock_w), .exec_lock(exec_lock_w)
);

// File: tb/test_otp_cmd_engine.sv
module test_otp_cmd_engine;

  localparam int ROWS = 16;
  localparam int LAT  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  otp_cmd_engine #(.WIDE(1'b1), .NUM_ROWS(ROWS), .BUSY_CYCLES(LAT)) i_otp_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Register write/readback table: {offset, write value, expected readback} (R2)
  localparam int NV = 7;
  localparam logic [71:0] VEC [NV] = '{
    {8'h04, 32'hFFFF_FFFF, 32'h0000_003F},
    {8'h04, 32'h1234_5688, 32'h0000_0008},
    {8'h28, 32'hABCD_1234, 32'h0000_1234},
    {8'h2C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {8'h64, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {8'h00, 32'hFFFF_FFFF, 32'h0000_0001},
    {8'h00, 32'hFFFF_FFFE, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Launch and poll; returns edges from start write to done (-1 if never)
  task automatic run(input logic [5:0] op, input logic [15:0] row,
                     input logic [31:0] lo, input logic [31:0] hi, output int lat);
    logic [31:0] s;
    wr(8'h04, 32'(op));
    wr(8'h28, 32'(row));
    wr(8'h2C, lo);
    wr(8'h64, hi);
    wr(8'h08, 32'h1);
    lat = -1;
    for (int k = 0; k < 50; k++) begin
      rd(8'h0C, s);
      if (s[1]) begin lat = k; break; end
      @(negedge clk);
    end
    wr(8'h08, 32'h0);
  endtask

  task automatic read_row(input logic [15:0] row, output logic [31:0] lo, output logic [31:0] hi);
    int l;
    run(6'h00, row, 32'h0, 32'h0, l);
    rd(8'h10, lo);
    rd(8'h5C, hi);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, lo, hi;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    foreach (VEC[i]) begin end
    rd(8'h00, v); check("R1 mode", v, 0);
    rd(8'h04, v); check("R1 cmd", v, 0);
    rd(8'h08, v); check("R1 start", v, 0);
    rd(8'h0C, v); check("R1 status", v, 0);
    rd(8'h28, v); check("R1 addr", v, 0);
    rd(8'h10, v); check("R1 rdata", v, 0);

    // R2 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      check("R2 readback", v, VEC[i][31:0]);
    end

    // R3 mode clear: start ignored
    wr(8'h08, 32'h1);
    repeat (8) @(negedge clk);
    rd(8'h0C, v); check("R3 no launch", v, 0);
    wr(8'h08, 32'h0);

    wr(8'h00, 32'h1);

    // R4 latency, busy, done clear
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h1);
    rd(8'h0C, v); check("R4 busy", v, 32'h1);
    lat = -1;
    for (int k = 0; k < 50; k++) begin
      rd(8'h0C, v);
      if (v[1]) begin lat = k; break; end
      @(negedge clk);
    end
    check("R4 latency", 32'(lat), 32'(LAT));
    rd(8'h0C, v); check("R4 done only", v, 32'h2);
    wr(8'h08, 32'h0);
    rd(8'h0C, v); check("R4 done cleared", v, 32'h0);

    // R9 program while locked
    run(6'h08, 16'd2, 32'h1111_0000, 32'h0000_2222, lat);
    check("R9 completes", 32'(lat), 32'(LAT));
    rd(8'h0C, v); check("R9 still locked", v, 0);
    read_row(16'd2, lo, hi);
    check("R9 row lo", lo, 0); check("R9 row hi", hi, 0);

    // R7 broken sequence
    run(6'h02, 0, 32'hF, 0, lat);
    run(6'h02, 0, 32'h4, 0, lat);
    run(6'h02, 0, 32'h7, 0, lat);
    run(6'h02, 0, 32'h8, 0, lat);
    run(6'h02, 0, 32'hD, 0, lat);
    rd(8'h0C, v); check("R7 no unlock", v[2], 0);

    // R6 correct sequence
    run(6'h02, 0, 32'hF, 0, lat);
    run(6'h02, 0, 32'h4, 0, lat);
    run(6'h02, 0, 32'h8, 0, lat);
    rd(8'h0C, v); check("R6 not yet", v[2], 0);
    run(6'h02, 0, 32'hD, 0, lat);
    rd(8'h0C, v); check("R6 unlocked", v[2], 1);

    // R8 program and OR merge, R5 read both words
    run(6'h08, 16'd2, 32'h1234_0000, 32'h0000_00F0, lat);
    read_row(16'd2, lo, hi);
    check("R5 R8 lo", lo, 32'h1234_0000); check("R5 R8 hi", hi, 32'h0000_00F0);
    run(6'h08, 16'd2, 32'h0000_00FF, 32'h0F00_0000, lat);
    read_row(16'd2, lo, hi);
    check("R8 merge lo", lo, 32'h1234_00FF); check("R8 merge hi", hi, 32'h0F00_00F0);

    // R11 out-of-range row
    run(6'h08, 16'd20, 32'hFFFF_FFFF, 32'hFFFF_FFFF, lat);
    read_row(16'd20, lo, hi);
    check("R11 read zero lo", lo, 0); check("R11 read zero hi", hi, 0);
    read_row(16'd4, lo, hi);
    check("R11 alias row4", lo, 0);
    read_row(16'd2, lo, hi);

    // R12 unknown code
    run(6'h3F, 16'd5, 32'hAAAA_AAAA, 0, lat);
    check("R12 completes", 32'(lat), 32'(LAT));
    rd(8'h0C, v); check("R12 prog ok kept", v[2], 1);
    rd(8'h10, v); check("R12 rdata kept", v, 32'h1234_00FF);

    // R10 lock again
    run(6'h03, 0, 0, 0, lat);
    check("R10 completes", 32'(lat), 32'(LAT));
    rd(8'h0C, v); check("R10 locked", v[2], 0);
    run(6'h08, 16'd3, 32'h5555_5555, 32'h5555_5555, lat);
    read_row(16'd3, lo, hi);
    check("R10 row unchanged", lo, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule